// File: doc/BRIEF.md
# Supervisor Control and Status Registers

This block holds the setup register and the event-flag register of a supply supervisor. The setup register enables a clock alarm, an oscillator run bit, a watchdog with a choice of output pin, a battery monitor and its two-bit threshold code. From these bits the block runs a watchdog timer counted in one-second ticks, issues battery-test strobes to an external comparator, latches events into the flag register and drives three active-low pins: a shared alarm pin, a dedicated watchdog pin and a reset pin.

Software reaches both registers through a one-bit-address read/write port. Reads are combinational. A write to the setup register stores bits 6:0. A write to the flag register ignores its data and clears every flag. The asynchronous reset stands for the battery power-up event. The `vccPor` input is a separate one-cycle main-supply power-on event.

Top module: `sup_regs`

## Requirements
- R1: Address 0 selects the setup register. A write stores `regWdata[6:0]`, and bit 7 always reads 0. Field positions are: bit 0 clock-alarm enable (cae), bit 1 oscillator run (osce), bit 2 watchdog enable (wde), bit 3 watchdog pin select (wdos), bits 5:4 threshold code, bit 6 battery-monitor enable (bme). Reset clears both registers to 00h.
- R2: Address 1 reads the flag register. Its layout is bit 0 clock alarm, bit 1 watchdog alarm, bit 2 battery alarm, bit 3 power-on, bit 4 brown-out, bit 5 reset, with bits 7:6 reading 0. Any write to address 1 clears all flags on that edge.
- R3: When a flag's set event occurs on the same edge as a clear, the flag reads 0 after that edge and reads 1 one cycle later.
- R4: A flag stays set after its cause goes away, until the register is cleared.
- R5: While wde is 1, the watchdog counts `secTick` pulses. The WD_SECS-th tick after the last restart sets the watchdog flag. While wde is 0, the count is held at zero.
- R6: The watchdog count restarts on a 0-to-1 change of wde, on `vccPor`, or on a rising edge of `wdKick`. A restart takes priority over a tick in the same cycle.
- R7: With wdos=0, a set watchdog flag drives `wdoN` low when wde=1. With wdos=1, it drives `almN` low instead.
- R8: `almN` is also low when cae and the clock-alarm flag are both 1, or when bme and the battery-alarm flag are both 1.
- R9: A battery test request arises one cycle after bme turns 1, on `vccPor`, and on every SECS_PER_HOUR-th `secTick`. `battTest` pulses high for one cycle on the edge after the request.
- R10: A test request is dropped unless bme, osce and `oscRun` are all 1.
- R11: On the edge where a test request is registered, the battery-alarm flag is set if `battLow` is 1.
- R12: `tripSel` equals setup bits 5:4.
- R13: `vccPor` sets the power-on and reset flags. `brownOut` sets the brown-out and reset flags. Either one drives `rstOutN` low for the cycle after the edge on which it is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (battery power-up) |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects setup, 1 selects flags |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| secTick | input | 1 | One-cycle pulse per second |
| wdKick | input | 1 | Watchdog kick; a rising edge restarts the count |
| vccPor | input | 1 | Main-supply power-on event |
| brownOut | input | 1 | Brown-out event |
| battLow | input | 1 | Comparator result, 1 when the battery is below threshold |
| oscRun | input | 1 | Oscillator running indication |
| alarmMatch | input | 1 | Clock alarm match event |
| tripSel | output | 2 | Threshold code for the comparator |
| almN | output | 1 | Shared alarm pin, active low |
| wdoN | output | 1 | Watchdog pin, active low |
| rstOutN | output | 1 | Reset pin, active low |
| battTest | output | 1 | Battery test strobe |

## Verification
The bench builds the block with WD_SECS=4 and SECS_PER_HOUR=6. With these values a watchdog expiry and an hourly battery test take only a few ticks, so both can be reached in directed steps. In the random phase, many expiries, hour wraps and restart-versus-tick collisions occur and are compared against a behavioural model. Directed steps cover the clear-versus-set collision, the choice of watchdog pin and each of the battery-test gating conditions.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int CTRL_W  = 7;
  localparam int CAE_B   = 0;
  localparam int OSCE_B  = 1;
  localparam int WDE_B   = 2;
  localparam int WDOS_B  = 3;
  localparam int TRIP_LO = 4;
  localparam int BME_B   = 6;

  localparam int NFLAG = 6;
  localparam int F_CLK = 0;
  localparam int F_WD  = 1;
  localparam int F_BAT = 2;
  localparam int F_POR = 3;
  localparam int F_BOR = 4;
  localparam int F_RST = 5;

  typedef struct packed {
    logic             ctrlWr;
    logic             statClr;
    logic             wdRestart;
    logic             secTick;
    logic             battReq;
    logic [NFLAG-1:0] extSet;
  } strobeT;
endpackage

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
#(
  parameter int SECS_PER_HOUR = 3600
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   regWe,
  input  logic   regAddr,
  input  logic   secTick,
  input  logic   wdKick,
  input  logic   vccPor,
  input  logic   brownOut,
  input  logic   battLow,
  input  logic   oscRun,
  input  logic   alarmMatch,
  input  logic   bme,
  input  logic   osce,
  input  logic   wde,
  output strobeT stb
);
  localparam int HR_W = $clog2(SECS_PER_HOUR);

  logic            bmeDly, wdeDly, kickDly;
  logic [HR_W-1:0] hrCnt;
  logic            hrLast, hourWrap, testReq;

  assign hrLast   = (hrCnt == HR_W'(SECS_PER_HOUR - 1));
  assign hourWrap = secTick && hrLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bmeDly  <= 1'b0;
      wdeDly  <= 1'b0;
      kickDly <= 1'b0;
      hrCnt   <= '0;
    end else begin
      bmeDly  <= bme;
      wdeDly  <= wde;
      kickDly <= wdKick;
      if (secTick) hrCnt <= hrLast ? '0 : hrCnt + 1'b1;
    end
  end

  assign testReq = ((bme && !bmeDly) || vccPor || hourWrap) && bme && osce && oscRun;

  always_comb begin
    stb.ctrlWr    = regWe && !regAddr;
    stb.statClr   = regWe && regAddr;
    stb.wdRestart = (wde && !wdeDly) || vccPor || (wdKick && !kickDly);
    stb.secTick   = secTick;
    stb.battReq   = testReq;
    stb.extSet        = '0;
    stb.extSet[F_CLK] = alarmMatch;
    stb.extSet[F_BAT] = testReq && battLow;
    stb.extSet[F_POR] = vccPor;
    stb.extSet[F_BOR] = brownOut;
    stb.extSet[F_RST] = vccPor || brownOut;
  end

  p_hour_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    hrCnt <= HR_W'(SECS_PER_HOUR - 1));
endmodule

// File: rtl/sup_dp.sv
module sup_dp
  import sup_pkg::*;
#(
  parameter int WD_SECS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [NFLAG-1:0]  flagsQ,
  output logic              battTest,
  output logic              rstOutN
);
  localparam int WD_W = $clog2(WD_SECS);
  localparam logic [7:0] CTRL_MASK = 8'((1 << CTRL_W) - 1);

  logic [7:0]       ctrlFull;
  logic [NFLAG-1:0] pendQ, setAll;
  logic [WD_W-1:0]  wdCnt;
  logic             wde, wdLast, wdExpire;

  assign wde      = ctrlFull[WDE_B];
  assign wdLast   = (wdCnt == WD_W'(WD_SECS - 1));
  assign wdExpire = wde && !stb.wdRestart && stb.secTick && wdLast;
  assign ctrlBits = ctrlFull[CTRL_W-1:0];

  always_comb begin
    setAll       = stb.extSet;
    setAll[F_WD] = wdExpire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlFull <= '0;
      flagsQ   <= '0;
      pendQ    <= '0;
      wdCnt    <= '0;
      battTest <= 1'b0;
      rstOutN  <= 1'b1;
    end else begin
      if (stb.ctrlWr) ctrlFull <= regWdata & CTRL_MASK;
      if (stb.statClr) begin
        flagsQ <= '0;
        pendQ  <= setAll;
      end else begin
        flagsQ <= flagsQ | setAll | pendQ;
        pendQ  <= '0;
      end
      if (!wde || stb.wdRestart) wdCnt <= '0;
      else if (stb.secTick)      wdCnt <= wdLast ? '0 : wdCnt + 1'b1;
      battTest <= stb.battReq;
      rstOutN  <= !stb.extSet[F_RST];
    end
  end

  assign regRdata = regAddr ? {{(8-NFLAG){1'b0}}, flagsQ} : ctrlFull;

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.statClr) |-> ((flagsQ & $past(flagsQ)) == $past(flagsQ)));
  p_clear_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.statClr |=> (flagsQ == '0));
  p_wd_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wdRestart |=> (wdCnt == '0));
  p_wd_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt <= WD_W'(WD_SECS - 1));
  p_test_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(battTest) |-> $past(ctrlFull[BME_B] && ctrlFull[OSCE_B]));
endmodule

// File: rtl/sup_regs.sv
module sup_regs
  import sup_pkg::*;
#(
  parameter int WD_SECS       = 8,
  parameter int SECS_PER_HOUR = 3600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       secTick,
  input  logic       wdKick,
  input  logic       vccPor,
  input  logic       brownOut,
  input  logic       battLow,
  input  logic       oscRun,
  input  logic       alarmMatch,
  output logic [1:0] tripSel,
  output logic       almN,
  output logic       wdoN,
  output logic       rstOutN,
  output logic       battTest
);
  strobeT            stb;
  logic [CTRL_W-1:0] ctrlBits;
  logic [NFLAG-1:0]  flagsQ;

  sup_ctrl #(.SECS_PER_HOUR(SECS_PER_HOUR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .secTick(secTick), .wdKick(wdKick), .vccPor(vccPor), .brownOut(brownOut),
    .battLow(battLow), .oscRun(oscRun), .alarmMatch(alarmMatch),
    .bme(ctrlBits[BME_B]), .osce(ctrlBits[OSCE_B]), .wde(ctrlBits[WDE_B]),
    .stb(stb)
  );

  sup_dp #(.WD_SECS(WD_SECS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .ctrlBits(ctrlBits), .flagsQ(flagsQ),
    .battTest(battTest), .rstOutN(rstOutN)
  );

  assign tripSel = ctrlBits[TRIP_LO +: 2];
  assign almN = !((ctrlBits[CAE_B] && flagsQ[F_CLK]) ||
                  (ctrlBits[BME_B] && flagsQ[F_BAT]) ||
                  (ctrlBits[WDE_B] && ctrlBits[WDOS_B] && flagsQ[F_WD]));
  assign wdoN = !(ctrlBits[WDE_B] && !ctrlBits[WDOS_B] && flagsQ[F_WD]);

  p_pin_route_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wdoN |-> (!ctrlBits[WDOS_B] && flagsQ[F_WD]));
endmodule

// File: tb/sim_sup_regs.sv
module sim_sup_regs;
  localparam int TO = 4;
  localparam int HR = 6;

  logic clk = 0, rstN = 0;
  logic regWe = 0, regAddr = 0, secTick = 0, wdKick = 0, vccPor = 0;
  logic brownOut = 0, battLow = 0, oscRun = 0, alarmMatch = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic [1:0] tripSel;
  logic almN, wdoN, rstOutN, battTest;

  int nChk = 0, nFail = 0, pulses = 0;

  sup_regs #(.WD_SECS(TO), .SECS_PER_HOUR(HR)) u0 (.*);

  always #4 clk = ~clk;

  // behavioural reference
  logic [6:0] mCtrl;
  logic [5:0] mFlags, mPend;
  int mWd, mHr;
  bit mBmeP, mWdeP, mKickP, mBt, mRst;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mFlags = 0; mPend = 0; mWd = 0; mHr = 0;
      mBmeP = 0; mWdeP = 0; mKickP = 0; mBt = 0; mRst = 1;
    end else begin
      bit bmeR, wdeR, kR, hrW, restart, req, expd, clr;
      logic [5:0] s;
      bmeR = mCtrl[6] && !mBmeP;
      wdeR = mCtrl[2] && !mWdeP;
      kR = wdKick && !mKickP;
      hrW = secTick && (mHr == HR-1);
      restart = wdeR || vccPor || kR;
      req = (bmeR || vccPor || hrW) && mCtrl[6] && mCtrl[1] && oscRun;
      expd = mCtrl[2] && !restart && secTick && (mWd == TO-1);
      s = {vccPor || brownOut, brownOut, vccPor, req && battLow, expd, alarmMatch};
      clr = regWe && regAddr;
      if (clr) begin mFlags = 0; mPend = s; end
      else begin mFlags = mFlags | s | mPend; mPend = 0; end
      if (!mCtrl[2] || restart) mWd = 0;
      else if (secTick) mWd = (mWd == TO-1) ? 0 : mWd + 1;
      if (secTick) mHr = (mHr == HR-1) ? 0 : mHr + 1;
      mBmeP = mCtrl[6]; mWdeP = mCtrl[2]; mKickP = wdKick;
      mBt = req; mRst = !(vccPor || brownOut);
      if (regWe && !regAddr) mCtrl = regWdata[6:0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (battTest) pulses++;
    if (rstN) begin
      logic [7:0] eRd;
      bit eAlm, eWdo;
      eRd = regAddr ? {2'b0, mFlags} : {1'b0, mCtrl};
      eAlm = !((mCtrl[0] && mFlags[0]) || (mCtrl[6] && mFlags[2]) ||
               (mCtrl[2] && mCtrl[3] && mFlags[1]));
      eWdo = !(mCtrl[2] && !mCtrl[3] && mFlags[1]);
      chk(regAddr ? "R2 rdata" : "R1 rdata", regRdata, eRd);
      chk("R8 almN", almN, eAlm);
      chk("R7 wdoN", wdoN, eWdo);
      chk("R9 battTest", battTest, mBt);
      chk("R12 tripSel", tripSel, mCtrl[5:4]);
      chk("R13 rstOutN", rstOutN, mRst);
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0; regAddr = 0;
    @(negedge clk);
  endtask
  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      secTick = 1; @(negedge clk); secTick = 0; @(negedge clk);
    end
  endtask
  task automatic rdStat(string tag, int exp);
    regAddr = 1; #1; chk(tag, regRdata, exp); regAddr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1; chk("R1 reset ctrl", regRdata, 0);
    rdStat("R2 reset flags", 0);
    wr(0, 8'hFF);
    #1; chk("R1 bit7 zero", regRdata, 8'h7F); chk("R12 trip", tripSel, 3);
    wr(0, 0); wr(1, 0);
    rdStat("R2 cleared", 0);
    // R3 clear vs set
    regWe = 1; regAddr = 1; alarmMatch = 1;
    @(negedge clk); regWe = 0; alarmMatch = 0;
    #1; chk("R3 clear wins", regRdata, 0);
    @(negedge clk); #1; chk("R3 re-set", regRdata, 1);
    regAddr = 0;
    repeat (3) @(negedge clk);
    rdStat("R4 latched", 1);
    #1; chk("R8 cae off", almN, 1);
    wr(0, 8'h01); #1; chk("R8 cae on", almN, 0);
    wr(0, 0); wr(1, 0);
    // watchdog
    wr(0, 8'h04);
    tick(TO-1); rdStat("R5 not yet", 0);
    wdKick = 1; @(negedge clk); wdKick = 0; @(negedge clk);
    tick(TO-1); rdStat("R6 kick restart", 0);
    tick(1); rdStat("R5 expiry", 2);
    #1; chk("R7 wdo pin", wdoN, 0); chk("R7 alm idle", almN, 1);
    wr(0, 8'h0C); #1; chk("R7 alm pin", almN, 0); chk("R7 wdo idle", wdoN, 1);
    wr(0, 0); wr(1, 0);
    // battery test gating
    oscRun = 1; battLow = 1; pulses = 0;
    wr(0, 8'h40); repeat (2) @(negedge clk);
    #1; chk("R10 no osce", pulses, 0); rdStat("R10 no flag", 0);
    wr(0, 0); pulses = 0;
    wr(0, 8'h42); repeat (2) @(negedge clk);
    #1; chk("R9 bme rise", pulses, 1); rdStat("R11 batt flag", 4);
    #1; chk("R8 batt alm", almN, 0);
    pulses = 0;
    vccPor = 1; @(negedge clk); vccPor = 0;
    #1; chk("R13 rst pin", rstOutN, 0);
    repeat (2) @(negedge clk);
    #1; chk("R9 por test", pulses, 1); rdStat("R13 por flags", 8'h2C);
    pulses = 0; tick(HR); @(negedge clk);
    #1; chk("R9 hourly", pulses, 1);
    wr(1, 0);
    brownOut = 1; @(negedge clk); brownOut = 0;
    #1; chk("R13 bor pin", rstOutN, 0);
    @(negedge clk); rdStat("R13 bor flags", 8'h30);
    oscRun = 0; wr(0, 8'h42); #1; chk("R10 osc down", battTest, 0);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      regWe = ($urandom % 8) == 0; regAddr = $urandom % 2; regWdata = 8'($urandom);
      secTick = ($urandom % 3) == 0; wdKick = ($urandom % 10) == 0;
      vccPor = ($urandom % 50) == 0; brownOut = ($urandom % 40) == 0;
      battLow = $urandom % 2; oscRun = ($urandom % 4) != 0;
      alarmMatch = ($urandom % 20) == 0;
    end
    @(negedge clk); regWe = 0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule